// File: doc/BRIEF.md
# FFT Result Block Output Sequencer

This block is the output side of a block transform engine whose size can be chosen. While the synchronous clear is high, it captures three settings: the transform length, the direction (forward or inverse) and a 7-bit gain-reduction code. It holds these settings and passes them on to the engine. At any other time, changes on the configuration inputs have no effect.

When the engine finishes a block, it sends a one-cycle done pulse together with that block's overflow status. The sequencer then reads the whole block from a result buffer, one word per clock, at addresses 0 to N-1. The buffer sits outside the block and returns data one cycle after the address. The sequencer presents each word on 16-bit real and imaginary outputs. Three indicators go with the data: a block-start strobe, a per-sample valid, and an overflow flag that belongs to the block.

A done pulse that arrives during a burst is held in a single pending slot. That block is then streamed directly after the current one, with no idle cycle between them. The output path uses no input-loading signals, so results can stream out while the engine loads new input.

Top module: `fft_out_burst`

## Requirements
- R1: The configuration outputs `eng_size`, `eng_inverse` and `eng_scale` take the values of `cfg_size`, `cfg_inverse` and `cfg_scale` at each clock edge where `clr` is high. At every other edge they hold their value.
- R2: The block length N is 2^LOG2_MIN for size code 2'b00, 2^(LOG2_MIN+1) for 2'b01, and 2^(LOG2_MIN+2) for both 2'b10 and 2'b11.
- R3: A done pulse sampled while no burst is active does the following. At the next edge, `buf_rd_en` rises with `buf_rd_addr` = 0. Two edges after the done edge, the first sample appears on `y_re`/`y_im`.
- R4: During a burst, `buf_rd_addr` steps by one each cycle from 0 to N-1 (natural order). `y_re`/`y_im` carry the buffer words in that order.
- R5: `y_valid` is high for exactly N cycles per block and low in every other cycle.
- R6: `y_start` is high only in the cycle that carries sample 0 of a block, and for one cycle only.
- R7: While `y_valid` is high, `y_re`/`y_im` equal the buffer word read for that sample, as 16-bit two's complement. While `y_valid` is low, both outputs are zero.
- R8: `y_ovf` equals the overflow status given with the block's done pulse, in every sample of that block. It is low when `y_valid` is low, and each new block replaces it.
- R9: A done pulse that arrives during a burst is queued. That block's sample 0 follows the current block's sample N-1 in the next cycle.
- R10: A done pulse that arrives while the pending slot is already full, and the current burst is not at its last address, is dropped: no extra block is produced.
- R11: `clr` stops any burst. After the clear edge, `buf_rd_en`, `y_valid`, `y_start` and `y_ovf` are low, and done pulses sampled during clear start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear; configuration capture window |
| cfg_size | input | 2 | Transform length code |
| cfg_inverse | input | 1 | 1 selects inverse transform |
| cfg_scale | input | SCALE_W | Gain-reduction code |
| eng_size | output | 2 | Captured length code |
| eng_inverse | output | 1 | Captured direction |
| eng_scale | output | SCALE_W | Captured gain-reduction code |
| eng_done | input | 1 | One-cycle pulse: a result block is ready |
| eng_ovf | input | 1 | Overflow status of the finished block, valid with eng_done |
| buf_rd_en | output | 1 | Result buffer read enable |
| buf_rd_addr | output | LOG2_MIN+2 | Result buffer read address |
| buf_rd_re | input | DW | Buffer real word, one cycle after the address |
| buf_rd_im | input | DW | Buffer imaginary word, one cycle after the address |
| y_start | output | 1 | First sample of a block |
| y_valid | output | 1 | Sample valid |
| y_re | output | DW | Output sample, real part |
| y_im | output | DW | Output sample, imaginary part |
| y_ovf | output | 1 | Overflow flag of the block being streamed |

## Verification
The bench builds the block with LOG2_MIN = 3, so the three lengths are 8, 16 and 32 samples. Every size code, including the alias code 11, can then be run to its final address several times in a short run. With these short blocks, a queued done pulse, a dropped third pulse and a clear in the middle of a burst all fall within a few cycles of each other. This allows back-to-back chaining and the block-to-block change of the overflow flag to be checked sample by sample.

// File: rtl/fob_pkg.sv
package fob_pkg;

  typedef enum logic [1:0] {
    SZ_BASE   = 2'b00,
    SZ_DOUBLE = 2'b01,
    SZ_QUAD   = 2'b10,
    SZ_ALIAS  = 2'b11
  } size_code_e;

  typedef struct packed {
    logic valid;
    logic start;
    logic ovf;
  } strobe_t;

  // Extra doublings of the base length selected by a size code.
  function automatic int unsigned size_shift(input logic [1:0] code);
    case (size_code_e'(code))
      SZ_BASE:   return 0;
      SZ_DOUBLE: return 1;
      default:   return 2;
    endcase
  endfunction

endpackage

// File: rtl/fob_cfg_regs.sv
module fob_cfg_regs #(
  parameter int SCALE_W = 7
) (
  input  logic               clk,
  input  logic               clr,
  input  logic [1:0]         size_in,
  input  logic               inv_in,
  input  logic [SCALE_W-1:0] scale_in,
  output logic [1:0]         size_q,
  output logic               inv_q,
  output logic [SCALE_W-1:0] scale_q
);

  // Settings are sampled only inside the clear window.
  always_ff @(posedge clk) begin
    if (clr) begin
      size_q  <= size_in;
      inv_q   <= inv_in;
      scale_q <= scale_in;
    end
  end

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !clr |=> ($stable(size_q) && $stable(inv_q) && $stable(scale_q)));

endmodule

// File: rtl/fob_sequencer.sv
module fob_sequencer
  import fob_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [AW-1:0] last_idx,
  input  logic          done,
  input  logic          done_ovf,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output strobe_t       issue
);

  logic          active_q;
  logic [AW-1:0] addr_q;
  logic          first_q;
  logic          cur_ovf_q;
  logic          pend_q;
  logic          pend_ovf_q;
  logic          at_last;

  assign at_last = active_q && (addr_q == last_idx);

  always_ff @(posedge clk) begin
    if (clr) begin
      active_q   <= 1'b0;
      addr_q     <= '0;
      first_q    <= 1'b0;
      cur_ovf_q  <= 1'b0;
      pend_q     <= 1'b0;
      pend_ovf_q <= 1'b0;
    end else begin
      first_q <= 1'b0;
      if (!active_q) begin
        if (done) begin
          active_q  <= 1'b1;
          addr_q    <= '0;
          first_q   <= 1'b1;
          cur_ovf_q <= done_ovf;
        end
      end else if (at_last) begin
        if (pend_q) begin
          addr_q     <= '0;
          first_q    <= 1'b1;
          cur_ovf_q  <= pend_ovf_q;
          pend_q     <= done;
          pend_ovf_q <= done_ovf;
        end else if (done) begin
          addr_q    <= '0;
          first_q   <= 1'b1;
          cur_ovf_q <= done_ovf;
        end else begin
          active_q <= 1'b0;
        end
      end else begin
        addr_q <= addr_q + 1'b1;
        if (done && !pend_q) begin
          pend_q     <= 1'b1;
          pend_ovf_q <= done_ovf;
        end
      end
    end
  end

  assign rd_en       = active_q;
  assign rd_addr     = addr_q;
  assign issue.valid = active_q;
  assign issue.start = first_q;
  assign issue.ovf   = cur_ovf_q;

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (clr)
    (rd_en && $past(rd_en) && rd_addr != '0) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R2
  addr_bound_chk: assert property (@(posedge clk) disable iff (clr)
    rd_en |-> (rd_addr <= last_idx));

  // R3
  burst_origin_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(rd_en) |-> (rd_addr == '0 && issue.start));

  // R10
  pend_needs_burst_chk: assert property (@(posedge clk) disable iff (clr)
    pend_q |-> active_q);

endmodule

// File: rtl/fob_out_stage.sv
module fob_out_stage
  import fob_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          clr,
  input  strobe_t       issue,
  input  logic [DW-1:0] rd_re,
  input  logic [DW-1:0] rd_im,
  output logic          y_start,
  output logic          y_valid,
  output logic          y_ovf,
  output logic [DW-1:0] y_re,
  output logic [DW-1:0] y_im
);

  strobe_t aligned;

  // Strobes wait RD_LAT cycles so they line up with the buffer data.
  for (genvar g = 0; g < RD_LAT; g++) begin : g_dly
    strobe_t q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) q <= clr ? '0 : issue;
    end else begin : g_next
      always_ff @(posedge clk) q <= clr ? '0 : g_dly[g-1].q;
    end
  end

  assign aligned = g_dly[RD_LAT-1].q;

  always_ff @(posedge clk) begin
    if (clr) begin
      y_valid <= 1'b0;
      y_start <= 1'b0;
      y_ovf   <= 1'b0;
      y_re    <= '0;
      y_im    <= '0;
    end else begin
      y_valid <= aligned.valid;
      y_start <= aligned.valid & aligned.start;
      y_ovf   <= aligned.valid & aligned.ovf;
      y_re    <= aligned.valid ? rd_re : '0;
      y_im    <= aligned.valid ? rd_im : '0;
    end
  end

  // R6
  start_in_valid_chk: assert property (@(posedge clk) disable iff (clr)
    y_start |-> y_valid);

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (clr)
    y_start |=> !y_start);

  // R8
  ovf_in_valid_chk: assert property (@(posedge clk) disable iff (clr)
    y_ovf |-> y_valid);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (clr)
    !y_valid |-> (y_re == '0 && y_im == '0));

endmodule

// File: rtl/fft_out_burst.sv
module fft_out_burst
  import fob_pkg::*;
#(
  parameter int DW       = 16,
  parameter int SCALE_W  = 7,
  parameter int LOG2_MIN = 11,
  parameter int RD_LAT   = 1,
  localparam int AW      = LOG2_MIN + 2
) (
  input  logic               clk,
  input  logic               clr,
  input  logic [1:0]         cfg_size,
  input  logic               cfg_inverse,
  input  logic [SCALE_W-1:0] cfg_scale,
  output logic [1:0]         eng_size,
  output logic               eng_inverse,
  output logic [SCALE_W-1:0] eng_scale,
  input  logic               eng_done,
  input  logic               eng_ovf,
  output logic               buf_rd_en,
  output logic [AW-1:0]      buf_rd_addr,
  input  logic [DW-1:0]      buf_rd_re,
  input  logic [DW-1:0]      buf_rd_im,
  output logic               y_start,
  output logic               y_valid,
  output logic [DW-1:0]      y_re,
  output logic [DW-1:0]      y_im,
  output logic               y_ovf
);

  logic [AW-1:0] last_idx;
  strobe_t       issue;

  fob_cfg_regs #(.SCALE_W(SCALE_W)) u_cfg (
    .clk      (clk),
    .clr      (clr),
    .size_in  (cfg_size),
    .inv_in   (cfg_inverse),
    .scale_in (cfg_scale),
    .size_q   (eng_size),
    .inv_q    (eng_inverse),
    .scale_q  (eng_scale)
  );

  always_comb begin
    last_idx = AW'((32'd1 << (LOG2_MIN + int'(size_shift(eng_size)))) - 32'd1);
  end

  fob_sequencer #(.AW(AW)) u_seq (
    .clk      (clk),
    .clr      (clr),
    .last_idx (last_idx),
    .done     (eng_done),
    .done_ovf (eng_ovf),
    .rd_en    (buf_rd_en),
    .rd_addr  (buf_rd_addr),
    .issue    (issue)
  );

  fob_out_stage #(.DW(DW), .RD_LAT(RD_LAT)) u_out (
    .clk     (clk),
    .clr     (clr),
    .issue   (issue),
    .rd_re   (buf_rd_re),
    .rd_im   (buf_rd_im),
    .y_start (y_start),
    .y_valid (y_valid),
    .y_ovf   (y_ovf),
    .y_re    (y_re),
    .y_im    (y_im)
  );

endmodule

// File: tb/tb_fft_out_burst.sv
module tb_fft_out_burst;

  localparam int DW = 16;
  localparam int SW = 7;
  localparam int LM = 3;
  localparam int AW = LM + 2;

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic [1:0]    cfg_size = 2'b00;
  logic          cfg_inverse = 1'b0;
  logic [SW-1:0] cfg_scale = '0;
  logic [1:0]    eng_size;
  logic          eng_inverse;
  logic [SW-1:0] eng_scale;
  logic          eng_done = 1'b0;
  logic          eng_ovf = 1'b0;
  logic          buf_rd_en;
  logic [AW-1:0] buf_rd_addr;
  logic [DW-1:0] buf_rd_re = '0;
  logic [DW-1:0] buf_rd_im = '0;
  logic          y_start, y_valid, y_ovf;
  logic [DW-1:0] y_re, y_im;

  always #2 clk = ~clk;

  fft_out_burst #(.DW(DW), .SCALE_W(SW), .LOG2_MIN(LM), .RD_LAT(1)) dut (
    .clk(clk), .clr(clr), .cfg_size(cfg_size), .cfg_inverse(cfg_inverse),
    .cfg_scale(cfg_scale), .eng_size(eng_size), .eng_inverse(eng_inverse),
    .eng_scale(eng_scale), .eng_done(eng_done), .eng_ovf(eng_ovf),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_re(buf_rd_re),
    .buf_rd_im(buf_rd_im), .y_start(y_start), .y_valid(y_valid),
    .y_re(y_re), .y_im(y_im), .y_ovf(y_ovf)
  );

  function automatic logic [DW-1:0] pat_re(input int a);
    return 16'h4000 + DW'(a * 3);
  endfunction
  function automatic logic [DW-1:0] pat_im(input int a);
    return 16'h8001 - DW'(a);
  endfunction

  // Result buffer model: one-cycle read latency.
  always @(posedge clk) begin
    buf_rd_re <= pat_re(int'(buf_rd_addr));
    buf_rd_im <= pat_im(int'(buf_rd_addr));
  end

  int checks = 0;
  int failures = 0;
  int n_cur = 8;
  logic [33:0] sb_q[$];
  logic          prev_en = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic          done_flag = 1'b0;

  task automatic check(input logic ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Driver: push the expected samples of one block.
  task automatic push_block(input logic ovf);
    for (int i = 0; i < n_cur; i++)
      sb_q.push_back({(i == 0), ovf, pat_re(i), pat_im(i)});
  endtask

  // Monitor: compare samples and addresses away from the clock edge.
  always @(negedge clk) begin
    logic [33:0] e;
    if (!clr && !done_flag) begin
      if (y_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R5 unexpected sample", 1, 0);
        end else begin
          e = sb_q.pop_front();
          check(y_re == e[31:16], "R7/R4 real word", y_re, e[31:16]);
          check(y_im == e[15:0], "R7/R4 imag word", y_im, e[15:0]);
          check(y_start == e[33], "R6 start strobe", y_start, e[33]);
          check(y_ovf == e[32], "R8 block overflow", y_ovf, e[32]);
        end
      end else if (y_start || y_ovf || y_re != 0 || y_im != 0) begin
        check(1'b0, "R7 idle outputs", {y_start, y_ovf}, 0);
      end
      if (buf_rd_en) begin
        logic [AW-1:0] ea;
        ea = (!prev_en || int'(prev_addr) == n_cur - 1) ? '0 : prev_addr + 1'b1;
        check(buf_rd_addr == ea, "R4 read address", buf_rd_addr, ea);
      end
    end
    prev_en   = buf_rd_en;
    prev_addr = buf_rd_addr;
  end

  task automatic pulse_done(input logic ovf);
    @(negedge clk);
    eng_done = 1'b1;
    eng_ovf  = ovf;
    @(negedge clk);
    eng_done = 1'b0;
    eng_ovf  = 1'b0;
  endtask

  task automatic reconfig(input logic [1:0] sz, input logic inv, input logic [SW-1:0] sc, input int n);
    @(negedge clk);
    cfg_size = sz; cfg_inverse = inv; cfg_scale = sc; clr = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0;
    n_cur = n;
    sb_q.delete();
  endtask

  task automatic wait_run(input int exp_len, input string tag);
    int k = 0;
    int guard = 0;
    while (!y_start && guard < 200) begin @(negedge clk); guard++; end
    while (y_valid) begin k++; @(negedge clk); end
    check(k == exp_len, tag, k, exp_len);
  endtask

  task automatic quiet_window(input int cyc, input string tag);
    int v = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (y_valid || buf_rd_en) v++; end
    check(v == 0, tag, v, 0);
    check(sb_q.size() == 0, "R5 all expected samples seen", sb_q.size(), 0);
  endtask

  initial begin
    // Reset state and configuration capture.
    cfg_size = 2'b00; cfg_inverse = 1'b1; cfg_scale = 7'h05;
    repeat (3) @(negedge clk);
    check(!y_valid && !y_start && !y_ovf && !buf_rd_en, "R11 reset outputs low",
          {y_valid, y_start, y_ovf, buf_rd_en}, 0);
    clr = 1'b0;
    n_cur = 8;
    cfg_size = 2'b10; cfg_inverse = 1'b0; cfg_scale = 7'h7A;
    @(negedge clk);
    check(eng_size == 2'b00 && eng_inverse == 1'b1 && eng_scale == 7'h05,
          "R1 config held outside clear", {eng_size, eng_inverse, eng_scale}, {2'b00, 1'b1, 7'h05});

    // R3 idle start timing.
    push_block(1'b0);
    pulse_done(1'b0);
    check(buf_rd_en && buf_rd_addr == 0, "R3 read begins at address 0", {buf_rd_en, buf_rd_addr}, 1 << AW);
    @(negedge clk);
    check(!y_valid, "R3 no sample before latency", y_valid, 0);
    @(negedge clk);
    check(y_start && y_valid, "R3 first sample two edges after done", {y_start, y_valid}, 3);
    while (y_valid) @(negedge clk);
    quiet_window(4, "R5 valid low after block");
    check(eng_size == 2'b00, "R1 size unchanged after burst", eng_size, 0);

    // R8 overflow block, length 8 with R2 code 00.
    push_block(1'b1);
    fork
      pulse_done(1'b1);
      wait_run(8, "R2 code 00 length");
    join
    quiet_window(4, "R5 valid low after overflow block");

    // R9 queued block back to back, R10 third pulse dropped.
    push_block(1'b0);
    push_block(1'b1);
    fork
      begin
        pulse_done(1'b0);
        repeat (2) @(negedge clk);
        pulse_done(1'b1);
        repeat (1) @(negedge clk);
        pulse_done(1'b0);
      end
      wait_run(16, "R9 two blocks without gap");
    join
    quiet_window(20, "R10 dropped pulse makes no block");

    // R2 other size codes; R1 new capture.
    reconfig(2'b01, 1'b0, 7'h33, 16);
    check(eng_size == 2'b01 && eng_inverse == 1'b0 && eng_scale == 7'h33,
          "R1 config captured in clear", {eng_size, eng_inverse, eng_scale}, {2'b01, 1'b0, 7'h33});
    push_block(1'b0);
    fork pulse_done(1'b0); wait_run(16, "R2 code 01 length"); join
    quiet_window(4, "R5 after 16-sample block");

    reconfig(2'b10, 1'b1, 7'h01, 32);
    push_block(1'b1);
    fork pulse_done(1'b1); wait_run(32, "R2 code 10 length"); join
    quiet_window(4, "R5 after 32-sample block");

    reconfig(2'b11, 1'b1, 7'h01, 32);
    push_block(1'b0);
    push_block(1'b1);
    fork
      begin pulse_done(1'b0); repeat (10) @(negedge clk); pulse_done(1'b1); end
      wait_run(64, "R2 code 11 alias length and R9 chain");
    join
    quiet_window(4, "R5 after alias blocks");

    // R11 clear aborts a burst; done during clear ignored.
    push_block(1'b0);
    pulse_done(1'b0);
    repeat (5) @(negedge clk);
    check(y_valid, "R11 burst running before clear", y_valid, 1);
    done_flag = 1'b1;
    clr = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    check(!y_valid && !buf_rd_en && !y_start && !y_ovf, "R11 clear stops burst",
          {y_valid, buf_rd_en, y_start, y_ovf}, 0);
    clr = 1'b0; eng_done = 1'b0;
    sb_q.delete();
    done_flag = 1'b0;
    quiet_window(12, "R11 done during clear starts nothing");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule